// File: doc/BRIEF.md
# Pluggable Module Reset and Interrupt Controller

This block is the low-speed management core of a pluggable optical module. It watches three host-side control lines: an active-low module select, an active-low module reset and a low-power-mode level. It drives an open-drain style interrupt, modelled as a pull-low enable that is never driven high. Each control line first passes through a two-flop synchronizer. The reset line is then filtered against a minimum low time, so that glitches and short pulses have no effect.

After power-up, and after every accepted reset, the block runs a timed initialization. A data-not-ready status bit stays set for the whole of that period. When it ends, the block clears data-not-ready, latches a reset-complete flag and pulls the interrupt line. Interrupt sources sit in a flag register that clears when it is read. The interrupt line releases once that register is empty.

A small register port gives the host access to status, flags and a control register. The control register holds per-lane transmit disables and a high-power request. The port accepts an access only while the module is selected, and it enables its read data only for accepted reads. The minimum reset width and the initialization time are stated in time units. They are turned into cycle counts from a clock-frequency parameter.

Top module: `modmgmt_ctl`

## Requirements
- R1: A register access is accepted only while the synchronized select is low. Select is sampled by a two-flop synchronizer, so sel_n must be low for at least 2 clock edges before the request. An access made while unselected leaves acc_rd_oe low and acc_rdata zero, has no effect on a write, and does not clear flags on a read.
- R2: A reset input that is low for fewer than RST_CYC = CLK_KHZ*RST_MIN_NS/1000000 consecutive cycles has no effect. Control, flags and data-not-ready keep their values.
- R3: A reset input that is low for RST_CYC cycles or more returns the control register to 0, clears every latched flag and sets data-not-ready (status bit 0).
- R4: Data-not-ready stays set for at least INIT_CYC = CLK_KHZ*INIT_US/1000 cycles after the reset input is released. It clears within INIT_CYC+6 cycles of the release.
- R5: When initialization ends, flag bit 0 (reset complete) is latched and irq_pull is asserted.
- R6: After power-on reset (por_n) is released, the same completion happens with no reset pulse: irq_pull is low for INIT_CYC-2 cycles and high by INIT_CYC+2 cycles.
- R7: irq_pull is high exactly while any flag is latched. A read of address 1 (flags; bit 0 = reset complete, bit 1 = low-power level changed) returns the flags and clears them, so irq_pull falls in the same cycle that the read data appears.
- R8: Status bit 1 reports the low-power level. hp_en equals control bit 7 while lpmode is low and is 0 while lpmode is high. A change of the lpmode level while data-not-ready is clear latches flag bit 1.
- R9: While data-not-ready is set, a status read returns 0x01, a flags read returns 0 and clears nothing, and lpmode changes latch no flag.
- R10: Address 2 is the control register. Bits [LANES-1:0] drive lane_dis and bit 7 is the high-power request. All other bits read 0, and address 3 reads 0.
- R11: Read data and acc_rd_oe appear on the cycle after an accepted read request. acc_rdata is 0 whenever acc_rd_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sel_n | input | 1 | Module select from host, active low |
| rst_n | input | 1 | Module reset request from host, active low, filtered |
| lpmode | input | 1 | Low-power cap from host, active high |
| acc_valid | input | 1 | Register access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, zero when not enabled |
| acc_rd_oe | output | 1 | Read data enable toward the shared bus |
| lane_dis | output | LANES | Per-lane transmit disable |
| hp_en | output | 1 | High-power enable after low-power suppression |
| irq_pull | output | 1 | Pull-low enable of the open-drain interrupt |

## Verification
The cases hardest to reach from the ports are the two edges of the reset filter and the behaviour of the registers while initialization is still running. To reach both, the bench sweeps the reset pulse length from one cycle to two beyond the threshold, and each length is followed by control and status readback. For every pulse that is accepted, it reads the registers and toggles lpmode inside the not-ready window. Then it counts cycles from the release to bracket the completion interrupt.

// File: rtl/mm_pkg.sv
package mm_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_FLAG = 2'd1,
    A_CTRL = 2'd2,
    A_RSVD = 2'd3
  } addr_e;

  // nanoseconds to clock cycles for a clock given in kHz
  function automatic int cyc_from_ns(int khz, int ns);
    longint prod;
    prod = longint'(khz) * longint'(ns);
    return int'(prod / 64'd1000000);
  endfunction

  // microseconds to clock cycles for a clock given in kHz
  function automatic int cyc_from_us(int khz, int us);
    longint prod;
    prod = longint'(khz) * longint'(us);
    return int'(prod / 64'd1000);
  endfunction

  // status byte as seen by the host; masked while not ready
  function automatic logic [DATA_W-1:0] status_view(logic nr, logic lp);
    logic [DATA_W-1:0] v;
    v = '0;
    if (nr) v[0] = 1'b1;
    else    v[1] = lp;
    return v;
  endfunction

endpackage

// File: rtl/mm_sync.sv
module mm_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end

endmodule

// File: rtl/mm_rst_filter.sv
module mm_rst_filter #(
  parameter int MIN_CYC = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_s,
  output logic fire,
  output logic hold
);

  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_CYC);
  localparam logic [CW-1:0] PRE  = CW'(MIN_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)           low_cnt <= '0;
    else if (rst_s)        low_cnt <= '0;
    else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
  end

  assign fire = !rst_s && (low_cnt == PRE);
  assign hold = (low_cnt == FULL);

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    fire |=> !fire); // R2
  AST_FIRE_AFTER_LOW: assert property (@(posedge clk) disable iff (!arst_n)
    fire |-> $past(!rst_s)); // R2

endmodule

// File: rtl/mm_init_timer.sv
module mm_init_timer #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic restart,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (restart) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign done = busy && !restart && (cnt == LAST);

  AST_BUSY_ON_RESTART: assert property (@(posedge clk) disable iff (!arst_n)
    restart |=> busy); // R4
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> !busy); // R4

endmodule

// File: rtl/mm_regs.sv
module mm_regs
  import mm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              fire,
  input  logic              nr,
  input  logic              done,
  input  logic              lp_s,
  input  logic              acc,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_oe,
  output logic [LANES-1:0]  lane_dis,
  output logic              hp_req,
  output logic              irq
);

  localparam int NFLAG = 2;

  logic [NFLAG-1:0]  flags;
  logic [NFLAG-1:0]  flag_set;
  logic              lp_d;
  logic              lp_chg;
  logic              rd_req;
  logic              rd_clr;
  logic              ctrl_wr;
  logic [DATA_W-1:0] rd_val;

  assign rd_req  = acc && !we;
  assign rd_clr  = rd_req && (addr_e'(addr) == A_FLAG) && !nr;
  assign ctrl_wr = acc && we && (addr_e'(addr) == A_CTRL);
  assign lp_chg  = (lp_s ^ lp_d) && !nr;
  assign flag_set = {lp_chg, done};

  always_comb begin
    rd_val = '0;
    case (addr_e'(addr))
      A_STAT: rd_val = status_view(nr, lp_s);
      A_FLAG: if (!nr) rd_val[NFLAG-1:0] = flags;
      A_CTRL: begin
        rd_val[LANES-1:0] = lane_dis;
        rd_val[DATA_W-1]  = hp_req;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) lp_d <= 1'b0;
    else         lp_d <= lp_s;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      flags <= '0;
    end else if (fire) begin
      flags <= '0;
    end else begin
      flags <= (rd_clr ? '0 : flags) | flag_set;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lane_dis <= '0;
      hp_req   <= 1'b0;
    end else if (fire) begin
      lane_dis <= '0;
      hp_req   <= 1'b0;
    end else if (ctrl_wr) begin
      lane_dis <= wdata[LANES-1:0];
      hp_req   <= wdata[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdata <= '0;
      rd_oe <= 1'b0;
    end else begin
      rdata <= rd_req ? rd_val : '0;
      rd_oe <= rd_req;
    end
  end

  assign irq = |flags;

  AST_FIRE_DEFAULTS: assert property (@(posedge clk) disable iff (!arst_n)
    fire |=> (lane_dis == '0) && !hp_req && !irq); // R3
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!arst_n)
    (done && !fire) |=> irq); // R5
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_clr && !done && !lp_chg) |=> !irq); // R7
  AST_NR_NO_LATCH: assert property (@(posedge clk) disable iff (!arst_n)
    (nr && !done && !irq) |=> !irq); // R9

endmodule

// File: rtl/modmgmt_ctl.sv
module modmgmt_ctl
  import mm_pkg::*;
#(
  parameter int CLK_KHZ    = 200000,
  parameter int RST_MIN_NS = 10000,
  parameter int INIT_US    = 100000,
  parameter int LANES      = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sel_n,
  input  logic              rst_n,
  input  logic              lpmode,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [1:0]        acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_rd_oe,
  output logic [LANES-1:0]  lane_dis,
  output logic              hp_en,
  output logic              irq_pull
);

  localparam int RST_CYC  = cyc_from_ns(CLK_KHZ, RST_MIN_NS);
  localparam int INIT_CYC = cyc_from_us(CLK_KHZ, INIT_US);

  // synchronized lines: bit0 select, bit1 reset, bit2 low-power
  logic [2:0] raw_in, syn_out;
  logic       sel_s, rst_s, lp_s;
  logic       rst_fire, rst_hold, init_restart;
  logic       not_ready, init_done;
  logic       acc_ok;
  logic       hp_req;

  assign raw_in = {lpmode, rst_n, sel_n};

  mm_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      (raw_in),
    .q      (syn_out)
  );

  assign sel_s = syn_out[0];
  assign rst_s = syn_out[1];
  assign lp_s  = syn_out[2];

  mm_rst_filter #(.MIN_CYC(RST_CYC)) u_filt (
    .clk    (clk),
    .arst_n (por_n),
    .rst_s  (rst_s),
    .fire   (rst_fire),
    .hold   (rst_hold)
  );

  assign init_restart = rst_fire || rst_hold;

  mm_init_timer #(.CYC(INIT_CYC)) u_init (
    .clk     (clk),
    .arst_n  (por_n),
    .restart (init_restart),
    .busy    (not_ready),
    .done    (init_done)
  );

  assign acc_ok = acc_valid && !sel_s;

  mm_regs #(.LANES(LANES)) u_regs (
    .clk      (clk),
    .arst_n   (por_n),
    .fire     (rst_fire),
    .nr       (not_ready),
    .done     (init_done),
    .lp_s     (lp_s),
    .acc      (acc_ok),
    .we       (acc_we),
    .addr     (acc_addr),
    .wdata    (acc_wdata),
    .rdata    (acc_rdata),
    .rd_oe    (acc_rd_oe),
    .lane_dis (lane_dis),
    .hp_req   (hp_req),
    .irq      (irq_pull)
  );

  assign hp_en = hp_req && !lp_s;

  AST_OE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!por_n)
    acc_rd_oe |-> $past(acc_valid && !acc_we && !sel_s)); // R1
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!por_n)
    !acc_rd_oe |-> (acc_rdata == '0)); // R11
  AST_NR_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    $past(acc_ok && !acc_we && (addr_e'(acc_addr) == A_FLAG) && not_ready)
    |-> (acc_rdata == '0)); // R9
  AST_LP_BLOCKS_HP: assert property (@(posedge clk) disable iff (!por_n)
    (lpmode && $past(lpmode) && $past(lpmode, 2)) |-> !hp_en); // R8

endmodule

// File: tb/modmgmt_ctl_tb.sv
`timescale 1ns/1ps
module modmgmt_ctl_tb;

  localparam int CLK_KHZ    = 1000;
  localparam int RST_MIN_NS = 8000;
  localparam int INIT_US    = 40;
  localparam int LANES      = 4;
  localparam int RC = (CLK_KHZ * RST_MIN_NS) / 1000000;
  localparam int IC = (CLK_KHZ * INIT_US) / 1000;

  logic       clk = 1'b0;
  logic       por_n, sel_n, rst_n, lpmode;
  logic       acc_valid, acc_we;
  logic [1:0] acc_addr;
  logic [7:0] acc_wdata, acc_rdata;
  logic       acc_rd_oe;
  logic [LANES-1:0] lane_dis;
  logic       hp_en, irq_pull;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  modmgmt_ctl #(
    .CLK_KHZ(CLK_KHZ), .RST_MIN_NS(RST_MIN_NS), .INIT_US(INIT_US), .LANES(LANES)
  ) u_dut (
    .clk(clk), .por_n(por_n), .sel_n(sel_n), .rst_n(rst_n), .lpmode(lpmode),
    .acc_valid(acc_valid), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_rd_oe(acc_rd_oe),
    .lane_dis(lane_dis), .hp_en(hp_en), .irq_pull(irq_pull)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
    acc_valid = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk);
    d = acc_rdata; oe = acc_rd_oe;
    acc_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    acc_valid = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = v;
    @(negedge clk);
    acc_valid = 1'b0; acc_we = 1'b0;
  endtask

  function automatic logic [7:0] ctrl_view(logic [7:0] v);
    return v & (8'h80 | 8'((1 << LANES) - 1));
  endfunction

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    int         rel;
    por_n = 1'b0; sel_n = 1'b0; rst_n = 1'b1; lpmode = 1'b0;
    acc_valid = 1'b0; acc_we = 1'b0; acc_addr = 2'd0; acc_wdata = 8'h00;
    tick(3);
    check("R6 reset irq", int'(irq_pull), 0);
    check("R11 reset oe", int'(acc_rd_oe), 0);
    por_n = 1'b1;
    rel = cyc;
    while (cyc < rel + IC - 2) @(negedge clk);
    check("R6 irq before init end", int'(irq_pull), 0);
    while (cyc < rel + IC + 2) @(negedge clk);
    check("R6 irq after power-up", int'(irq_pull), 1);

    rd(2'd0, d, oe);
    check("R4 status ready", int'(d), 0);
    check("R11 oe on read", int'(oe), 1);
    tick(1);
    check("R11 oe idle", int'(acc_rd_oe), 0);
    check("R11 data idle", int'(acc_rdata), 0);

    // unselected accesses
    sel_n = 1'b1; tick(3);
    rd(2'd1, d, oe);
    check("R1 unselected oe", int'(oe), 0);
    check("R1 unselected data", int'(d), 0);
    check("R1 unselected read keeps irq", int'(irq_pull), 1);
    wr(2'd2, 8'h85);
    sel_n = 1'b0; tick(3);
    rd(2'd2, d, oe);
    check("R1 unselected write ignored", int'(d), 0);

    rd(2'd1, d, oe);
    check("R5 completion flag", int'(d), 1);
    check("R7 irq released by read", int'(irq_pull), 0);
    rd(2'd1, d, oe);
    check("R7 flags cleared", int'(d), 0);

    // control register sweep
    for (int v = 0; v < 256; v += 17) begin
      wr(2'd2, 8'(v));
      rd(2'd2, d, oe);
      check("R10 ctrl readback", int'(d), int'(ctrl_view(8'(v))));
      check("R10 lane_dis", int'(lane_dis), v & ((1 << LANES) - 1));
      check("R8 hp_en", int'(hp_en), (v >> 7) & 1);
    end
    rd(2'd3, d, oe);
    check("R10 reserved", int'(d), 0);

    // low-power level
    wr(2'd2, 8'h80);
    lpmode = 1'b1; tick(4);
    check("R8 hp suppressed", int'(hp_en), 0);
    check("R8 lp irq", int'(irq_pull), 1);
    rd(2'd0, d, oe);
    check("R8 lp status", int'(d), 2);
    rd(2'd1, d, oe);
    check("R8 lp flag", int'(d), 2);
    lpmode = 1'b0; tick(4);
    check("R8 hp restored", int'(hp_en), 1);
    rd(2'd1, d, oe);
    check("R8 lp flag on fall", int'(d), 2);
    check("R7 irq low", int'(irq_pull), 0);

    // reset pulse length sweep
    for (int len = 1; len <= RC + 2; len++) begin
      automatic bit fired = (len >= RC);
      wr(2'd2, 8'h85);
      rst_n = 1'b0; tick(len); rst_n = 1'b1;
      rel = cyc;
      tick(2);
      rd(2'd2, d, oe);
      check(fired ? "R3 ctrl default" : "R2 ctrl kept", int'(d), fired ? 0 : 8'h85);
      rd(2'd0, d, oe);
      check(fired ? "R3 not ready" : "R2 still ready", int'(d), fired ? 1 : 0);
      rd(2'd1, d, oe);
      check(fired ? "R9 flags hidden" : "R2 no flags", int'(d), 0);
      check(fired ? "R3 irq cleared" : "R2 irq quiet", int'(irq_pull), 0);
      if (fired) begin
        lpmode = 1'b1; tick(3);
        rd(2'd0, d, oe);
        check("R9 status masked", int'(d), 1);
        lpmode = 1'b0; tick(3);
        while (cyc < rel + IC - 1) @(negedge clk);
        check("R4 irq not before init", int'(irq_pull), 0);
        while (cyc < rel + IC + 6) @(negedge clk);
        check("R5 irq after init", int'(irq_pull), 1);
        rd(2'd0, d, oe);
        check("R4 ready after init", int'(d), 0);
        rd(2'd1, d, oe);
        check("R9 only completion flag", int'(d), 1);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule